// File: doc/BRIEF.md
# Warp Page-Stride Detector and Compressed Miss Table

This block sits between a translation coalescer and the page walker of a wide SIMD core. After one warp memory instruction has been reduced to its distinct virtual page numbers, the coalescer hands them over one per cycle, in thread-index order. While they stream in, the block tests whether they lie on one constant page stride. It also marks any page that an outstanding miss already covers.

When the whole set lies on one stride, the block writes a single compressed miss entry into a small miss table. The entry holds a base page, a signed stride and a lane mask, so one entry stands in for up to 32 misses. When the set is irregular, or holds only one page, the block writes one plain entry per page. Each entry it writes is also shown on an allocation output, which the walker uses as its request. Walk replies come back one page at a time. Each reply clears the mask bit it matches, and an entry whose mask reaches zero is freed.

Top module: `stride_fold_mshr`

## Requirements
- R1: After synchronous reset the table is empty, `in_ready` is 1, and `alloc_valid` and `retire_mask` are 0.
- R2: A warp of two or more pages ends with `in_last`, or with its 32nd page. Its stride is the second page minus the first, modulo 2^20. If every later page equals the previous page plus that stride, the cycle after the last page is accepted shows one allocation. That allocation has `alloc_base` = first page, `alloc_stride` = stride, and `alloc_mask` bit i set for the i-th page (lane i) when that page is not already covered.
- R3: The stride is a two's-complement 20-bit field, so descending sequences are compressed (for example, a step of -2 is 20'hFFFFE).
- R4: A warp with a broken stride, or with a single page, is filed one lane per cycle in lane order, starting the cycle after its last page. Each uncovered lane gives an allocation with base = that page, stride = 0 and mask = 32'h1. A covered lane uses its cycle without allocating.
- R5: A reply page matches lane i of a live entry when mask bit i is set and base + i*stride equals the reply page, modulo 2^20. A match clears that bit at the next edge. In the reply cycle, `retire_mask` bit e is 1 exactly when entry e becomes empty through that reply. A reply that matches nothing changes nothing.
- R6: `in_ready` is 1 only while pages are being gathered. It is 0 from the cycle after a warp's last page until its filing ends. Filing stalls, with no allocation, while every entry is live.
- R7: A page that a live entry covers on the cycle the page is accepted is not allocated again. If every page of a regular warp is covered, the warp allocates nothing.
- R8: `alloc_slot` is the lowest-numbered entry that is empty at the start of the allocation cycle.
- R9: A reply in an allocation cycle does not act on the entry being written. An entry freed by that reply is not reused in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A distinct page of the current warp is offered |
| in_vpn | input | 20 | Offered virtual page number |
| in_last | input | 1 | Offered page is the warp's last one |
| in_ready | output | 1 | Pages are being accepted |
| rsp_valid | input | 1 | A page walk has completed |
| rsp_vpn | input | 20 | Page number of the completed walk |
| alloc_valid | output | 1 | An entry is written this cycle |
| alloc_slot | output | 2 | Entry index being written |
| alloc_base | output | 20 | Base page of the written entry |
| alloc_stride | output | 20 | Signed stride of the written entry |
| alloc_mask | output | 32 | Lane mask of the written entry |
| retire_mask | output | 4 | Entries emptied by this cycle's reply |

## Verification
Two functions can fall in the same cycle: writing a new entry, and clearing or freeing an entry because of a reply. The bench lines up a reply with a filing cycle in two ways. In one case, the reply empties the only live entry while the next single-page warp is filed. In the other, the reply names the very page being filed. A behavioural model of the table, built from page lists, judges every cycle: which slot is written, that the freed slot is not reused, and that the new entry survives. A further case holds filing stalled on a full table until a reply frees an entry, to show that the freed entry is reused only on the following cycle.

// File: rtl/sfold_pkg.sv
package sfold_pkg;

    localparam int VPN_W       = 20;
    localparam int LANES       = 32;
    localparam int LANE_W      = $clog2(LANES);
    localparam int CNT_W       = $clog2(LANES + 1);
    localparam int DEF_ENTRIES = 4;

    typedef logic [VPN_W-1:0]        vpn_t;
    typedef logic signed [VPN_W-1:0] stride_t;
    typedef logic [LANES-1:0]        lane_mask_t;
    typedef logic [LANE_W-1:0]       lane_idx_t;
    typedef logic [CNT_W-1:0]        lane_cnt_t;

    // One outstanding-miss record: lane i stands for base + i*stride.
    typedef struct packed {
        vpn_t       base;
        stride_t    stride;
        lane_mask_t mask;
    } miss_desc_t;

    typedef enum logic {
        ST_GATHER,
        ST_FILE
    } fold_state_e;

    function automatic vpn_t lane_page(vpn_t base, stride_t stride, int unsigned lane);
        vpn_t step;
        step = vpn_t'(stride) * vpn_t'(lane);
        return base + step;
    endfunction

endpackage

// File: rtl/sfold_lane_match.sv
module sfold_lane_match
    import sfold_pkg::*;
(
    input  miss_desc_t desc,
    input  vpn_t       probe,
    output lane_mask_t hit
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign hit[i] = desc.mask[i] && (lane_page(desc.base, desc.stride, i) == probe);
    end
endmodule

// File: rtl/sfold_stride_track.sv
module sfold_stride_track
    import sfold_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic       restart,
    input  vpn_t       vpn,
    input  logic       covered,
    input  lane_idx_t  rd_idx,
    output vpn_t       rd_vpn,
    output lane_mask_t fresh,
    output lane_cnt_t  count,
    output stride_t    stride,
    output logic       regular
);
    vpn_t pages [LANES];
    vpn_t last_vpn;

    always_ff @(posedge clk) begin
        if (take) begin
            pages[lane_idx_t'(count)] <= vpn;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            count    <= '0;
            fresh    <= '0;
            regular  <= 1'b1;
            stride   <= '0;
            last_vpn <= '0;
        end else if (take) begin
            fresh[lane_idx_t'(count)] <= !covered;
            last_vpn <= vpn;
            count    <= count + 1'b1;
            if (count == lane_cnt_t'(1)) begin
                stride <= stride_t'(vpn - last_vpn);
            end else if (count > lane_cnt_t'(1) && vpn != last_vpn + vpn_t'(stride)) begin
                regular <= 1'b0;
            end
        end
    end

    assign rd_vpn = pages[rd_idx];
endmodule

// File: rtl/sfold_miss_table.sv
module sfold_miss_table
    import sfold_pkg::*;
#(
    parameter  int ENTRIES = DEF_ENTRIES,
    localparam int SLOT_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc_en,
    input  logic [SLOT_W-1:0]  alloc_slot,
    input  miss_desc_t         alloc_desc,
    input  logic               rsp_valid,
    input  vpn_t               rsp_vpn,
    input  vpn_t               probe_vpn,
    output logic               probe_hit,
    output logic               free_ok,
    output logic [SLOT_W-1:0]  free_slot,
    output logic [ENTRIES-1:0] live,
    output logic [ENTRIES-1:0] retire
);
    typedef logic [SLOT_W-1:0] slot_t;

    logic [ENTRIES-1:0] probe_any;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        miss_desc_t ent;
        lane_mask_t rsp_lane;
        lane_mask_t probe_lane;

        sfold_lane_match u_reply (.desc(ent), .probe(rsp_vpn),   .hit(rsp_lane));
        sfold_lane_match u_probe (.desc(ent), .probe(probe_vpn), .hit(probe_lane));

        assign live[e]      = |ent.mask;
        assign probe_any[e] = |probe_lane;
        assign retire[e]    = rsp_valid && (|rsp_lane) && ((ent.mask & ~rsp_lane) == '0);

        always_ff @(posedge clk) begin
            if (rst) begin
                ent <= '0;
            end else if (alloc_en && alloc_slot == slot_t'(e)) begin
                ent <= alloc_desc;
            end else if (rsp_valid) begin
                ent.mask <= ent.mask & ~rsp_lane;
            end
        end
    end

    assign probe_hit = |probe_any;

    always_comb begin
        free_ok   = 1'b0;
        free_slot = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (!live[e]) begin
                free_ok   = 1'b1;
                free_slot = slot_t'(e);
            end
        end
    end
endmodule

// File: rtl/stride_fold_mshr.sv
module stride_fold_mshr
    import sfold_pkg::*;
#(
    parameter  int ENTRIES = DEF_ENTRIES,
    localparam int SLOT_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [VPN_W-1:0]        in_vpn,
    input  logic                    in_last,
    output logic                    in_ready,
    input  logic                    rsp_valid,
    input  logic [VPN_W-1:0]        rsp_vpn,
    output logic                    alloc_valid,
    output logic [SLOT_W-1:0]       alloc_slot,
    output logic [VPN_W-1:0]        alloc_base,
    output logic signed [VPN_W-1:0] alloc_stride,
    output logic [LANES-1:0]        alloc_mask,
    output logic [ENTRIES-1:0]      retire_mask
);
    fold_state_e        state;
    lane_idx_t          ptr;
    logic               take, warp_end, compressed, need, advance, done, restart;
    vpn_t               rd_vpn;
    lane_mask_t         fresh;
    lane_cnt_t          count;
    stride_t            stride;
    logic               regular, covered, free_ok;
    logic [SLOT_W-1:0]  free_slot;
    logic [ENTRIES-1:0] live;
    miss_desc_t         new_desc;

    assign in_ready   = (state == ST_GATHER);
    assign take       = in_valid && in_ready;
    assign warp_end   = take && (in_last || count == lane_cnt_t'(LANES - 1));
    assign compressed = regular && (count >= lane_cnt_t'(2));

    always_comb begin
        need    = compressed ? (fresh != '0) : fresh[ptr];
        advance = !need || free_ok;
        done    = advance && (compressed || ptr == lane_idx_t'(count - 1'b1));
        new_desc.base   = rd_vpn;
        new_desc.stride = compressed ? stride : '0;
        new_desc.mask   = compressed ? fresh : lane_mask_t'(1);
    end

    assign alloc_valid  = (state == ST_FILE) && need && free_ok;
    assign alloc_slot   = free_slot;
    assign alloc_base   = new_desc.base;
    assign alloc_stride = new_desc.stride;
    assign alloc_mask   = new_desc.mask;
    assign restart      = (state == ST_FILE) && done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_GATHER;
            ptr   <= '0;
        end else if (state == ST_GATHER) begin
            ptr <= '0;
            if (warp_end) state <= ST_FILE;
        end else if (done) begin
            state <= ST_GATHER;
            ptr   <= '0;
        end else if (advance) begin
            ptr <= ptr + 1'b1;
        end
    end

    sfold_stride_track u_track (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .restart (restart),
        .vpn     (in_vpn),
        .covered (covered),
        .rd_idx  (compressed ? lane_idx_t'(0) : ptr),
        .rd_vpn  (rd_vpn),
        .fresh   (fresh),
        .count   (count),
        .stride  (stride),
        .regular (regular)
    );

    sfold_miss_table #(.ENTRIES(ENTRIES)) u_table (
        .clk        (clk),
        .rst        (rst),
        .alloc_en   (alloc_valid),
        .alloc_slot (free_slot),
        .alloc_desc (new_desc),
        .rsp_valid  (rsp_valid),
        .rsp_vpn    (rsp_vpn),
        .probe_vpn  (in_vpn),
        .probe_hit  (covered),
        .free_ok    (free_ok),
        .free_slot  (free_slot),
        .live       (live),
        .retire     (retire_mask)
    );
endmodule

// File: rtl/sfold_checker.sv
module sfold_checker
    import sfold_pkg::*;
#(
    parameter  int ENTRIES = DEF_ENTRIES,
    localparam int SLOT_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_ready,
    input logic                    alloc_valid,
    input logic [SLOT_W-1:0]       alloc_slot,
    input logic signed [VPN_W-1:0] alloc_stride,
    input logic [LANES-1:0]        alloc_mask,
    input logic [ENTRIES-1:0]      retire_mask,
    input logic [ENTRIES-1:0]      live
);
    // R4: a plain entry carries exactly lane 0
    a_r4_plain_single_lane: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_stride == '0) |-> (alloc_mask == LANES'(1)))
        else $error("a_r4_plain_single_lane");

    // R7: nothing is written for a set that is fully covered
    a_r7_no_empty_write: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |-> (alloc_mask != '0))
        else $error("a_r7_no_empty_write");

    // R8: the written slot was empty
    a_r8_slot_was_free: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |-> !live[alloc_slot])
        else $error("a_r8_slot_was_free");

    // R9: the written slot is live afterwards even if a reply arrived alongside
    a_r9_write_survives: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |=> live[$past(alloc_slot)])
        else $error("a_r9_write_survives");

    // R5: only live entries retire, and a retired entry is empty afterwards
    a_r5_retire_was_live: assert property (@(posedge clk) disable iff (rst)
        (retire_mask & ~live) == '0)
        else $error("a_r5_retire_was_live");

    a_r5_retire_frees: assert property (@(posedge clk) disable iff (rst)
        (|retire_mask) |=> ((live & $past(retire_mask)) == '0))
        else $error("a_r5_retire_frees");

    // R6: no page is accepted while entries are being written
    a_r6_closed_while_filing: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |-> !in_ready)
        else $error("a_r6_closed_while_filing");
endmodule

bind stride_fold_mshr sfold_checker #(.ENTRIES(ENTRIES)) u_check (
    .clk          (clk),
    .rst          (rst),
    .in_ready     (in_ready),
    .alloc_valid  (alloc_valid),
    .alloc_slot   (alloc_slot),
    .alloc_stride (alloc_stride),
    .alloc_mask   (alloc_mask),
    .retire_mask  (retire_mask),
    .live         (live)
);

// File: tb/stride_fold_mshr_bench.sv
module stride_fold_mshr_bench;
    import sfold_pkg::*;

    localparam int NE = 4;
    localparam int VM = (1 << VPN_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [19:0]       in_vpn = '0;
    logic              in_last = 1'b0;
    logic              in_ready;
    logic              rsp_valid = 1'b0;
    logic [19:0]       rsp_vpn = '0;
    logic              alloc_valid;
    logic [1:0]        alloc_slot;
    logic [19:0]       alloc_base;
    logic signed [19:0] alloc_stride;
    logic [31:0]       alloc_mask;
    logic [3:0]        retire_mask;

    always #5 clk = ~clk;

    stride_fold_mshr #(.ENTRIES(NE)) u_stride_fold_mshr (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_vpn(in_vpn), .in_last(in_last),
        .in_ready(in_ready), .rsp_valid(rsp_valid), .rsp_vpn(rsp_vpn),
        .alloc_valid(alloc_valid), .alloc_slot(alloc_slot), .alloc_base(alloc_base),
        .alloc_stride(alloc_stride), .alloc_mask(alloc_mask), .retire_mask(retire_mask)
    );

    int    checks = 0;
    int    failures = 0;
    bit    running = 0;
    string cur_req = "R2";
    int    n_alloc = 0;
    int    n_ret = 0;

    // ---------------- behavioural model ----------------
    int        mpg [32];
    bit        mfr [32];
    int        mcnt, mptr;
    bit        mfiling;
    int        mb [NE];
    int        msd [NE];
    bit [31:0] mm [NE];

    bit        e_ready, e_av, e_done, e_adv;
    int        e_slot, e_base, e_stride;
    bit [31:0] e_mask;
    bit [3:0]  e_ret;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit [31:0] lane_hits(int e, int v);
        bit [31:0] h = '0;
        for (int i = 0; i < 32; i++)
            if (mm[e][i] && (((mb[e] + msd[e] * i) & VM) == v)) h[i] = 1'b1;
        return h;
    endfunction

    function automatic bit set_is_regular();
        int d;
        if (mcnt < 2) return 1'b0;
        d = (mpg[1] - mpg[0]) & VM;
        for (int k = 2; k < mcnt; k++)
            if (((mpg[0] + d * k) & VM) != mpg[k]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic void compute_exp();
        bit ff = 0;
        bit need;
        e_slot = 0;
        for (int e = NE - 1; e >= 0; e--) if (mm[e] == 0) begin ff = 1; e_slot = e; end
        e_ready = !mfiling;
        e_av = 0; e_done = 0; e_adv = 0; e_base = 0; e_stride = 0; e_mask = 0;
        if (mfiling) begin
            if (set_is_regular()) begin
                for (int k = 0; k < mcnt; k++) if (mfr[k]) e_mask[k] = 1'b1;
                need = (e_mask != 0);
                e_base = mpg[0];
                e_stride = (mpg[1] - mpg[0]) & VM;
                e_av = need && ff;
                e_done = !need || ff;
            end else begin
                need = mfr[mptr];
                e_base = mpg[mptr];
                e_mask = 32'h1;
                e_av = need && ff;
                e_adv = !need || ff;
                e_done = e_adv && (mptr == mcnt - 1);
            end
        end
        e_ret = 0;
        for (int e = 0; e < NE; e++) begin
            bit [31:0] c = lane_hits(e, int'(rsp_vpn));
            if (rsp_valid && c != 0 && (mm[e] & ~c) == 0) e_ret[e] = 1'b1;
        end
    endfunction

    always @(posedge clk) begin : model_step
        bit cov;
        if (rst) begin
            mcnt = 0; mptr = 0; mfiling = 0;
            for (int k = 0; k < 32; k++) begin mpg[k] = 0; mfr[k] = 0; end
            for (int e = 0; e < NE; e++) begin mb[e] = 0; msd[e] = 0; mm[e] = 0; end
        end else begin
            compute_exp();
            cov = 0;
            if (!mfiling && in_valid)
                for (int e = 0; e < NE; e++) if (lane_hits(e, int'(in_vpn)) != 0) cov = 1;
            for (int e = 0; e < NE; e++) begin
                if (e_av && e == e_slot) begin
                    mb[e] = e_base; msd[e] = e_stride; mm[e] = e_mask;
                end else if (rsp_valid) begin
                    mm[e] = mm[e] & ~lane_hits(e, int'(rsp_vpn));
                end
            end
            if (!mfiling && in_valid) begin
                mpg[mcnt] = int'(in_vpn);
                mfr[mcnt] = !cov;
                mcnt++;
                if (in_last || mcnt == 32) begin mfiling = 1; mptr = 0; end
            end else if (mfiling) begin
                if (e_done) begin
                    mfiling = 0; mcnt = 0;
                    for (int k = 0; k < 32; k++) mfr[k] = 0;
                end else if (e_adv) begin
                    mptr++;
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && running) begin
            compute_exp();
            check(in_ready === e_ready, "R6", "in_ready", in_ready, e_ready);
            check(alloc_valid === e_av, cur_req, "alloc_valid", alloc_valid, e_av);
            if (e_av && alloc_valid) begin
                check(int'(alloc_slot) == e_slot, "R8", "alloc_slot", alloc_slot, e_slot);
                check(int'(alloc_base) == e_base, cur_req, "alloc_base", alloc_base, e_base);
                check((int'($unsigned(alloc_stride)) & VM) == e_stride, cur_req,
                      "alloc_stride", $unsigned(alloc_stride), e_stride);
                check(alloc_mask === e_mask, cur_req, "alloc_mask", alloc_mask, e_mask);
            end
            check(retire_mask === e_ret, "R5", "retire_mask", retire_mask, e_ret);
            if (alloc_valid) n_alloc++;
            if (retire_mask != 0) n_ret++;
        end
    end

    // ---------------- stimulus ----------------
    int wp [32];

    task automatic fill_stride(input int base, input int step, input int n);
        for (int k = 0; k < n; k++) wp[k] = (base + step * k) & VM;
    endtask

    task automatic send_warp(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            while (!in_ready) begin @(posedge clk); #1; end
            in_valid = 1'b1; in_vpn = 20'(wp[k]); in_last = (k == n - 1);
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic reply(input int v);
        @(posedge clk); #1;
        rsp_valid = 1'b1; rsp_vpn = 20'(v);
        @(posedge clk); #1;
        rsp_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        running = 1;
        #2;
        check(in_ready === 1'b1, "R1", "in_ready after reset", in_ready, 1);
        check(alloc_valid === 1'b0, "R1", "alloc_valid after reset", alloc_valid, 0);
        check(retire_mask === 4'b0, "R1", "retire_mask after reset", retire_mask, 0);

        // R2: ascending stride of 3
        cur_req = "R2"; n_alloc = 0;
        fill_stride('h100, 3, 8);
        send_warp(8); idle(3);
        check(n_alloc == 1, "R2", "allocations for 8-page regular warp", n_alloc, 1);

        // R7: fully covered warp, then partly covered warp
        cur_req = "R7"; n_alloc = 0;
        wp[0] = 'h103; wp[1] = 'h106;
        send_warp(2); idle(3);
        check(n_alloc == 0, "R7", "allocations for covered warp", n_alloc, 0);
        wp[0] = 'h106; wp[1] = 'h200;
        send_warp(2); idle(3);
        check(n_alloc == 1, "R7", "allocations for half-covered warp", n_alloc, 1);

        // R5: replies drain both entries
        n_ret = 0;
        reply('h200);
        for (int k = 0; k < 8; k++) reply('h100 + 3 * k);
        idle(2);
        check(n_ret == 2, "R5", "retire pulses after draining", n_ret, 2);

        // R3: descending stride of -2, stray reply first
        cur_req = "R3"; n_alloc = 0; n_ret = 0;
        fill_stride('h5000, -2, 5);
        send_warp(5); idle(3);
        check(n_alloc == 1, "R3", "allocations for descending warp", n_alloc, 1);
        reply('h7777); idle(1);
        check(n_ret == 0, "R5", "retire pulses for unmatched reply", n_ret, 0);
        for (int k = 4; k >= 0; k--) reply('h5000 - 2 * k);
        idle(2);
        check(n_ret == 1, "R3", "retire pulses after descending drain", n_ret, 1);

        // R4: broken stride and single page fill the table
        cur_req = "R4"; n_alloc = 0;
        wp[0] = 'h10; wp[1] = 'h20; wp[2] = 'h35;
        send_warp(3); idle(4);
        wp[0] = 'h999;
        send_warp(1); idle(3);
        check(n_alloc == 4, "R4", "plain allocations", n_alloc, 4);

        // R6: full table stalls filing until a reply frees an entry
        cur_req = "R6"; n_alloc = 0;
        wp[0] = 'h40; wp[1] = 'h50;
        send_warp(2); idle(2);
        check(in_ready === 1'b0, "R6", "in_ready while stalled", in_ready, 0);
        check(n_alloc == 0, "R6", "allocations while full", n_alloc, 0);
        reply('h10); idle(3);
        check(n_alloc == 1, "R6", "allocations after entry freed", n_alloc, 1);
        reply('h20); reply('h35); reply('h999); reply('h40); reply('h50);
        idle(2);

        // R9: replies coinciding with allocation cycles
        cur_req = "R9"; n_ret = 0;
        wp[0] = 'h70;
        send_warp(1); idle(2);
        @(posedge clk); #1;
        in_valid = 1'b1; in_vpn = 20'h80; in_last = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0;
        rsp_valid = 1'b1; rsp_vpn = 20'h70;
        @(posedge clk); #1;
        rsp_valid = 1'b0;
        idle(1);
        @(posedge clk); #1;
        in_valid = 1'b1; in_vpn = 20'h90; in_last = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0;
        rsp_valid = 1'b1; rsp_vpn = 20'h90;
        @(posedge clk); #1;
        rsp_valid = 1'b0;
        idle(2);
        check(n_ret == 1, "R9", "retire pulses after coinciding replies", n_ret, 1);
        reply('h90); reply('h80); idle(2);
        check(n_ret == 3, "R9", "retire pulses after final drain", n_ret, 3);

        // R2: full 32-lane warp with unit stride
        cur_req = "R2"; n_alloc = 0; n_ret = 0;
        fill_stride('h1000, 1, 32);
        send_warp(32); idle(3);
        check(n_alloc == 1, "R2", "allocations for 32-lane warp", n_alloc, 1);
        for (int k = 0; k < 32; k++) reply('h1000 + k);
        idle(2);
        check(n_ret == 1, "R5", "retire pulses after 32-lane drain", n_ret, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule